// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

This block is the timekeeping core of a real-time clock. It runs from a 32768 Hz enable pulse, `tick`, that is synchronous to the bus clock. On each tick a 48-bit free-running counter advances by one. Bits [14:0] of the counter count sub-second ticks and bits [47:15] count whole seconds. A 48-bit compare value sits beside the counter. When a tick brings the counter to the compare value, a sticky alarm flag is set. A level interrupt presents that flag, gated by an enable input.

Software reaches the block through a 16-bit register port with a one-bit window select and a 5-bit byte offset. The time window holds the counter and the compare value, each split into three halfwords. The interrupt window holds the status register. Reads are combinational. A multi-halfword read of the running counter is not atomic, so software reads all three halfwords twice and accepts the value only when both passes agree.

Top module: `rtc_elapsed_alarm`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the counter, the compare value and the alarm flag are all zero, every readable offset returns 0 and alarm_irq is low.
- R2: The counter increases by exactly one, modulo 2^48, on each clock edge where tick is 1. It holds its value when tick is 0. The carry runs through all three halfwords, and all-ones wraps to zero.
- R3: In the time window (reg_win = 0), offsets 0x00, 0x02 and 0x04 read counter bits [15:0], [31:16] and [47:32]. Seconds bit 0 is therefore bit 15 of offset 0x00.
- R4: A write to one counter halfword replaces that halfword at the same edge. The other halfwords take their ticked value, including a carry out of the low halfword.
- R5: In the time window, offsets 0x08, 0x0A and 0x0C write and read back compare bits [15:0], [31:16] and [47:32]. An all-zero compare value, as left by reset, does not raise the flag unless a tick brings the counter to zero.
- R6: The alarm flag is set at an edge where tick is 1, no counter halfword is written, and the counter value plus one equals the compare value held before that edge. No other cycle sets the flag.
- R7: The flag stays set until a write in the interrupt window (reg_win = 1) to offset 0x1E with bit 0 = 1. A write with bit 0 = 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends set.
- R8: A read of offset 0x1E in the interrupt window returns the flag in bit 0, with bits [15:1] zero.
- R9: alarm_irq equals the alarm flag ANDed with alarm_en, with no register in between.
- R10: Any other offset or window (odd offsets, 0x06, 0x0E to 0x1C, time-window offsets in the interrupt window) reads 0. A write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | 32768 Hz advance pulse, one clock wide |
| reg_win | input | 1 | Window select: 0 time window, 1 interrupt window |
| reg_addr | input | 5 | Byte offset within the window |
| reg_wen | input | 1 | Write strobe for reg_wdata |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_win/reg_addr |
| alarm_en | input | 1 | Interrupt enable |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
On every cycle the embedded assertions check these properties:
- The counter holds or steps by one.
- A written halfword lands in its register.
- A compare write reaches the compare register.
- The flag never rises without a clean tick and never drops without a clear.
- Only one register target is decoded at a time.
- The interrupt is gated by the enable.

Some behaviours can only be shown by the bench's scenarios, where a behavioural model is compared on every clock:
- Carry and wrap across halfwords.
- The exact match instant.
- Suppression of a match by a coinciding counter write.
- Set winning over clear.
- Silence of unmapped offsets.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared layout constants for the elapsed-time/alarm core.
// Assumes byte offsets are even and halfword registers sit two bytes apart.
package rtc_alarm_pkg;
    localparam int CNT_W      = 48;  // counter and compare width
    localparam int HW_W       = 16;  // register bus width
    localparam int ADDR_W     = 5;   // byte offset width
    localparam int CNT_OFS    = 0;   // first counter halfword
    localparam int CMP_OFS    = 8;   // first compare halfword
    localparam int STAT_OFS   = 30;  // status register in interrupt window
    localparam int ALARM_BIT  = 0;   // alarm bit in status register

    typedef enum logic {
        WIN_TIME = 1'b0,
        WIN_INT  = 1'b1
    } win_e;
endpackage

// File: rtl/rtc_tick_count.sv
// Module: free-running elapsed-time counter with per-halfword overwrite.
// Assumes tick_i is a single-cycle enable. A halfword write overrides only its
// own slice of the ticked value, so carries still reach the other slices.
module rtc_tick_count #(
    parameter int CNT_W = 48,
    parameter int HW_W  = 16,
    localparam int NHW  = CNT_W / HW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [NHW-1:0]   hw_we_i,
    input  logic [HW_W-1:0]  wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_inc_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ticked;
    logic [CNT_W-1:0] cnt_d;

    // Purpose: value the counter takes on a tick, wrapping modulo 2^CNT_W.
    always_comb cnt_inc_o = cnt_q + CNT_W'(1);

    // Purpose: choose between hold and advance.
    always_comb ticked = tick_i ? cnt_inc_o : cnt_q;

    // Purpose: replace written halfwords, keep ticked value elsewhere.
    for (genvar k = 0; k < NHW; k++) begin : g_slice
        assign cnt_d[k*HW_W +: HW_W] = hw_we_i[k] ? wdata_i : ticked[k*HW_W +: HW_W];

        assert_hw_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hw_we_i[k] |=> cnt_q[k*HW_W +: HW_W] == $past(wdata_i));
    end

    // Purpose: counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && hw_we_i == '0) |=> $stable(cnt_q));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hw_we_i == '0) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: alarm compare register and sticky alarm flag.
// Assumes cnt_inc_i is the counter value plus one. A match counts only on a
// tick with no counter write. A set wins over a clear in the same cycle.
module rtc_alarm_cmp #(
    parameter int CNT_W = 48,
    parameter int HW_W  = 16,
    localparam int NHW  = CNT_W / HW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_inc_i,
    input  logic [NHW-1:0]   hw_we_i,
    input  logic [HW_W-1:0]  wdata_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             flag_o
);
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;
    logic             hit;

    // Purpose: compare registers, one halfword slice per generate step.
    for (genvar k = 0; k < NHW; k++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)          cmp_q[k*HW_W +: HW_W] <= '0;
            else if (hw_we_i[k]) cmp_q[k*HW_W +: HW_W] <= wdata_i;
        end

        assert_cmp_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hw_we_i[k] |=> cmp_q[k*HW_W +: HW_W] == $past(wdata_i));
    end

    // Purpose: detect the tick that brings the counter onto the compare value.
    always_comb hit = tick_i && !cnt_wr_i && (cnt_inc_i == cmp_q);

    // Purpose: sticky flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (hit)  flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign cmp_o  = cmp_q;
    assign flag_o = flag_q;

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    assert_flag_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && (!tick_i || cnt_wr_i)) |=> !flag_q);
endmodule

// File: rtl/rtc_reg_map.sv
// Module: register decode and read multiplexer for both windows.
// Assumes even byte offsets. Anything not decoded reads zero and is ignored
// on write.
module rtc_reg_map
    import rtc_alarm_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int HW_W   = 16,
    parameter int ADDR_W = 5,
    localparam int NHW   = CNT_W / HW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [HW_W-1:0]   wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  cmp_i,
    input  logic              flag_i,
    output logic [NHW-1:0]    cnt_we_o,
    output logic [NHW-1:0]    cmp_we_o,
    output logic              clr_o,
    output logic [HW_W-1:0]   rdata_o
);
    logic [NHW-1:0] cnt_sel;
    logic [NHW-1:0] cmp_sel;
    logic           stat_sel;

    // Purpose: per-halfword address decode in the time window.
    for (genvar k = 0; k < NHW; k++) begin : g_dec
        assign cnt_sel[k] = (win_i == WIN_TIME) && (addr_i == ADDR_W'(CNT_OFS + 2*k));
        assign cmp_sel[k] = (win_i == WIN_TIME) && (addr_i == ADDR_W'(CMP_OFS + 2*k));
    end

    // Purpose: status register decode in the interrupt window.
    always_comb stat_sel = (win_i == WIN_INT) && (addr_i == ADDR_W'(STAT_OFS));

    // Purpose: write strobes toward the counter, compare and flag.
    always_comb begin
        cnt_we_o = wen_i ? cnt_sel : '0;
        cmp_we_o = wen_i ? cmp_sel : '0;
        clr_o    = wen_i && stat_sel && wdata_i[ALARM_BIT];
    end

    // Purpose: combinational read multiplexer, zero when nothing decodes.
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NHW; k++) begin
            if (cnt_sel[k]) rdata_o = cnt_i[k*HW_W +: HW_W];
            if (cmp_sel[k]) rdata_o = cmp_i[k*HW_W +: HW_W];
        end
        if (stat_sel) rdata_o[ALARM_BIT] = flag_i;
    end

    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_we_o, cmp_we_o, clr_o}));
endmodule

// File: rtl/rtc_elapsed_alarm.sv
// Module: top of the elapsed-time counter with alarm compare.
// Assumes tick is synchronous to clk and one cycle wide. Register reads are
// combinational from reg_win and reg_addr.
module rtc_elapsed_alarm
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_win,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [HW_W-1:0]   reg_wdata,
    output logic [HW_W-1:0]   reg_rdata,
    input  logic              alarm_en,
    output logic              alarm_irq
);
    localparam int NHW = CNT_W / HW_W;

    logic [NHW-1:0]   cnt_we;
    logic [NHW-1:0]   cmp_we;
    logic             clr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cmp;
    logic             flag;

    rtc_reg_map #(.CNT_W(CNT_W), .HW_W(HW_W), .ADDR_W(ADDR_W)) u_map (
        .clk(clk), .rst_n(rst_n), .win_i(reg_win), .addr_i(reg_addr),
        .wen_i(reg_wen), .wdata_i(reg_wdata), .cnt_i(cnt), .cmp_i(cmp),
        .flag_i(flag), .cnt_we_o(cnt_we), .cmp_we_o(cmp_we), .clr_o(clr),
        .rdata_o(reg_rdata)
    );

    rtc_tick_count #(.CNT_W(CNT_W), .HW_W(HW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .hw_we_i(cnt_we),
        .wdata_i(reg_wdata), .cnt_o(cnt), .cnt_inc_o(cnt_inc)
    );

    rtc_alarm_cmp #(.CNT_W(CNT_W), .HW_W(HW_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_wr_i(|cnt_we),
        .cnt_inc_i(cnt_inc), .hw_we_i(cmp_we), .wdata_i(reg_wdata),
        .clr_i(clr), .cmp_o(cmp), .flag_o(flag)
    );

    // Purpose: level interrupt, flag gated by the enable.
    always_comb alarm_irq = flag && alarm_en;

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_en);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!alarm_irq && reg_rdata == '0) || !rst_n || reg_addr != $past(reg_addr) || reg_win != $past(reg_win));
endmodule

// File: tb/sim_rtc_elapsed_alarm.sv
`timescale 1ns/1ps
// Bench: behavioural model of counter, compare and flag, compared every clock.
module sim_rtc_elapsed_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_win = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        alarm_en = 1'b0;
    logic        alarm_irq;

    always #4 clk = ~clk;

    rtc_elapsed_alarm u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_win(reg_win),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_en(alarm_en), .alarm_irq(alarm_irq)
    );

    localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

    longint unsigned m_cnt = 0;
    longint unsigned m_cmp = 0;
    bit              m_flag = 1'b0;
    int              n_chk = 0;
    int              n_fail = 0;
    string           phase = "R1";
    bit              live = 1'b0;

    // Model: next state from the inputs applied at this edge.
    always @(posedge clk) begin
        longint unsigned nxt;
        bit cw, set, clr;
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_flag = 0;
        end else begin
            nxt = tick ? ((m_cnt + 1) & MASK) : m_cnt;
            cw = 0;
            for (int k = 0; k < 3; k++) begin
                if (reg_wen && !reg_win && reg_addr == 5'(2*k)) begin
                    nxt = (nxt & ~(64'hFFFF << (16*k))) | (longint'(reg_wdata) << (16*k));
                    cw = 1;
                end
            end
            set = tick && !cw && (((m_cnt + 1) & MASK) == m_cmp);
            clr = reg_wen && reg_win && reg_addr == 5'd30 && reg_wdata[0];
            for (int k = 0; k < 3; k++)
                if (reg_wen && !reg_win && reg_addr == 5'(8 + 2*k))
                    m_cmp = (m_cmp & ~(64'hFFFF << (16*k))) | (longint'(reg_wdata) << (16*k));
            m_cnt = nxt;
            m_flag = set ? 1'b1 : (clr ? 1'b0 : m_flag);
        end
    end

    function automatic logic [15:0] m_read();
        if (!reg_win) begin
            for (int k = 0; k < 3; k++) begin
                if (reg_addr == 5'(2*k))     return 16'(m_cnt >> (16*k));
                if (reg_addr == 5'(8 + 2*k)) return 16'(m_cmp >> (16*k));
            end
            return 16'h0;
        end
        return (reg_addr == 5'd30) ? {15'h0, m_flag} : 16'h0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: compare outputs with the model at the falling edge, then drive.
    task automatic step(input logic tk, input logic we, input logic w,
                        input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        if (live) begin
            check(phase, reg_rdata, m_read());
            check(phase, alarm_irq, m_flag & alarm_en);
        end
        tick = tk; reg_wen = we; reg_win = w; reg_addr = a; reg_wdata = d;
    endtask

    // Idle read with an explicit, independently stated expectation.
    task automatic peek(input logic w, input logic [4:0] a, input logic [15:0] exp,
                        input string req);
        step(0, 0, w, a, 0);
        @(negedge clk);
        check(req, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1: every readable offset is zero after reset
        phase = "R1";
        peek(0, 5'h00, 16'h0, "R1");
        peek(0, 5'h04, 16'h0, "R1");
        peek(0, 5'h0C, 16'h0, "R1");
        peek(1, 5'h1E, 16'h0, "R1");
        // R2 and R3: irregular tick pattern, read each halfword
        phase = "R2";
        for (int i = 0; i < 40; i++) step((i % 3) != 0, 0, 0, 5'(2*(i % 3)), 0);
        phase = "R3";
        peek(0, 5'h00, 16'd26, "R3");
        peek(0, 5'h02, 16'h0, "R3");
        // R4: carry out of a written low halfword, then a mid write while ticking
        phase = "R4";
        step(0, 1, 0, 5'h00, 16'hFFFE);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 5'h02, 0);
        step(0, 0, 0, 5'h02, 0);
        step(1, 1, 0, 5'h02, 16'h1234);
        step(1, 0, 0, 5'h00, 0);
        peek(0, 5'h02, 16'h1234, "R4");
        peek(0, 5'h00, 16'h0004, "R4");
        // R2: all-ones wraps to zero
        phase = "R2";
        step(0, 1, 0, 5'h00, 16'hFFFF);
        step(0, 1, 0, 5'h02, 16'hFFFF);
        step(0, 1, 0, 5'h04, 16'hFFFF);
        step(1, 0, 0, 5'h04, 0);
        peek(0, 5'h04, 16'h0, "R2");
        peek(0, 5'h00, 16'h0, "R2");
        // R5: compare readback
        phase = "R5";
        step(0, 1, 0, 5'h08, 16'hA5A5);
        step(0, 1, 0, 5'h0A, 16'h5A5A);
        step(0, 1, 0, 5'h0C, 16'h0F0F);
        peek(0, 5'h0A, 16'h5A5A, "R5");
        // R6 and R9: match sets the flag, irq follows enable
        phase = "R6";
        step(0, 1, 0, 5'h08, 16'h0020);
        step(0, 1, 0, 5'h0A, 16'h0000);
        step(0, 1, 0, 5'h0C, 16'h0000);
        step(0, 1, 0, 5'h00, 16'h001C);
        alarm_en = 1'b1;
        for (int i = 0; i < 6; i++) step(1, 0, 1, 5'h1E, 0);
        peek(1, 5'h1E, 16'h0001, "R6");
        phase = "R9";
        check("R9", alarm_irq, 1'b1);
        alarm_en = 1'b0;
        step(0, 0, 1, 5'h1E, 0);
        step(0, 0, 1, 5'h1E, 0);
        check("R9", alarm_irq, 1'b0);
        alarm_en = 1'b1;
        // R7: clear with zero has no effect, with one clears
        phase = "R7";
        step(0, 1, 1, 5'h1E, 16'hFFFE);
        peek(1, 5'h1E, 16'h0001, "R7");
        step(0, 1, 1, 5'h1E, 16'h0001);
        peek(1, 5'h1E, 16'h0000, "R7");
        // R7: set beats a clear in the same cycle
        step(0, 1, 0, 5'h00, 16'h001F);
        step(1, 1, 1, 5'h1E, 16'h0001);
        peek(1, 5'h1E, 16'h0001, "R7");
        step(0, 1, 1, 5'h1E, 16'h0001);
        // R6: a counter write in the match cycle suppresses the set
        phase = "R6";
        step(0, 1, 0, 5'h00, 16'h001F);
        step(1, 1, 0, 5'h00, 16'h0005);
        peek(1, 5'h1E, 16'h0000, "R6");
        peek(0, 5'h00, 16'h0005, "R6");
        // R8: status upper bits stay zero
        phase = "R8";
        step(0, 1, 0, 5'h00, 16'h001F);
        step(1, 0, 1, 5'h1E, 0);
        peek(1, 5'h1E, 16'h0001, "R8");
        step(0, 1, 1, 5'h1E, 16'hFFFF);
        // R10: unmapped offsets and windows
        phase = "R10";
        step(0, 1, 0, 5'h06, 16'hBEEF);
        step(0, 1, 0, 5'h01, 16'hBEEF);
        step(0, 1, 0, 5'h10, 16'hBEEF);
        step(0, 1, 1, 5'h00, 16'hBEEF);
        step(0, 1, 1, 5'h08, 16'hBEEF);
        peek(0, 5'h06, 16'h0, "R10");
        peek(0, 5'h01, 16'h0, "R10");
        peek(1, 5'h00, 16'h0, "R10");
        peek(0, 5'h00, 16'h0020, "R10");
        peek(0, 5'h08, 16'h0020, "R10");
        // R1: reset again from a busy state
        phase = "R1";
        step(0, 1, 0, 5'h00, 16'h001F);
        step(1, 0, 0, 5'h00, 0);
        live = 1'b0;
        rst_n = 1'b0;
        step(0, 0, 0, 5'h00, 0);
        step(0, 0, 0, 5'h00, 0);
        rst_n = 1'b1;
        live = 1'b1;
        peek(0, 5'h00, 16'h0, "R1");
        peek(0, 5'h08, 16'h0, "R1");
        peek(1, 5'h1E, 16'h0, "R1");
        check("R1", alarm_irq, 1'b0);
        step(0, 0, 0, 5'h00, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule